// File: doc/BRIEF.md
# Chaining DMA Address Generator

This block produces the memory address for one DMA channel. A 16-bit in-channel address counter forms the low half of the address, and a page register forms the upper bits. This lets a channel reach memory beyond a single 64 KB window. Every `advance` strobe stands for one finished transfer. On each strobe the counter moves up by one and the remaining count moves down by one. When an advance arrives while the count is already zero, the channel has reached terminal count.

The mode chosen at start-up decides what happens at terminal count:

- **Single-block mode:** the channel stops.
- **Ring mode:** the counter, page and count are reloaded from the programmed base, so the channel keeps cycling through one fixed memory range.
- **Chaining mode:** the channel switches with no gap to a preloaded next address, page and count. It then pulses a chain request so that software can refill the next set. This lets scatter-write and gather-read streams span several buffers.

Channel index 4 serves to cascade two controllers, so a start that names channel 4 is refused.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset, `addr` is 0 and `active`, `done`, `tc`, `chain_req` and `next_valid` are all 0.
- R2: A `prog_start` pulse whose `prog_ch` is not 4 makes `addr` equal {`prog_page`,`prog_base`}, sets `active` and clears `done` on the next cycle.
- R3: A `prog_start` pulse with `prog_ch` equal to 4 is ignored: `active`, `done` and `addr` keep their values.
- R4: An `advance` pulse while `active` is set and the remaining count is nonzero adds one to `addr[15:0]` and subtracts one from the count. An `advance` while `active` is clear changes nothing.
- R5: When `addr[15:0]` moves from 0xFFFF to 0x0000, the page bits `addr[23:16]` do not change.
- R6: An `advance` while the remaining count is zero is terminal count. `tc` is high for exactly the next cycle, so a programmed count N yields N+1 transfers.
- R7: Mode 0 (single) at terminal count clears `active`, sets `done` and leaves `addr` unchanged. Later `advance` pulses have no effect.
- R8: Mode 1 (ring) at terminal count reloads `addr` to {base page, base address} and the count to the programmed count, and `active` stays set.
- R9: Mode 2 (chain) at terminal count, with `next_valid` set, loads `addr` to {`next_page`,`next_base`} and the count to `next_count`. It pulses `chain_req` for one cycle, clears `next_valid` and keeps `active` set.
- R10: Mode 2 at terminal count with `next_valid` clear stops the channel: `active` clears and `done` sets.
- R11: Mode code 3 behaves exactly as mode 0.
- R12: A `next_load` pulse sets `next_valid` on the next cycle and captures the next address, page and count.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_start | input | 1 | Load the current set and begin |
| prog_ch | input | 3 | Channel index for the start (4 is refused) |
| prog_mode | input | 2 | 0 single, 1 ring, 2 chain, 3 single |
| prog_base | input | 16 | Starting in-channel address |
| prog_page | input | PAGE_W | Starting page |
| prog_count | input | 16 | Transfers minus one |
| next_load | input | 1 | Capture the next buffer set |
| next_base | input | 16 | Next buffer address |
| next_page | input | PAGE_W | Next buffer page |
| next_count | input | 16 | Next buffer transfers minus one |
| advance | input | 1 | One transfer completed |
| addr | output | PAGE_W+16 | Current memory address {page, counter} |
| active | output | 1 | Channel running |
| done | output | 1 | Channel stopped at terminal count |
| tc | output | 1 | Terminal count reached, one-cycle pulse |
| chain_req | output | 1 | Next set consumed, one-cycle pulse |
| next_valid | output | 1 | A next set is waiting |

## Verification
Every output is registered. Each result therefore appears exactly one clock edge after the strobe that causes it: `addr`, `active` and `done` follow `prog_start` or `advance` by one cycle, and `tc` and `chain_req` are high only in that cycle. The bench changes its inputs just after a rising edge and reads the outputs just after the following edge. It also reads one cycle later to confirm that the pulses have dropped again. The terminal-count scenarios count out N+1 advances, so that the transfer before terminal count and the terminal-count transfer itself are each checked at their own edge.

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int PAGE_W    = 8,
  parameter int CH_W      = 3,
  parameter int CASCADE_CH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                prog_start,
  input  logic [CH_W-1:0]     prog_ch,
  input  logic [1:0]          prog_mode,
  input  logic [15:0]         prog_base,
  input  logic [PAGE_W-1:0]   prog_page,
  input  logic [15:0]         prog_count,
  input  logic                next_load,
  input  logic [15:0]         next_base,
  input  logic [PAGE_W-1:0]   next_page,
  input  logic [15:0]         next_count,
  input  logic                advance,
  output logic [PAGE_W+15:0]  addr,
  output logic                active,
  output logic                done,
  output logic                tc,
  output logic                chain_req,
  output logic                next_valid
);
  localparam logic [1:0] M_RING  = 2'd1;
  localparam logic [1:0] M_CHAIN = 2'd2;

  logic [15:0]       cur_lo, cnt, base_lo, base_cnt, nx_lo, nx_cnt;
  logic [PAGE_W-1:0] cur_pg, base_pg, nx_pg;
  logic [1:0]        mode;

  wire start_ok = prog_start && (prog_ch != CH_W'(CASCADE_CH));
  wire step     = active && advance && !start_ok;
  wire at_tc    = step && (cnt == 16'd0);

  assign addr = {cur_pg, cur_lo};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_lo <= '0; cur_pg <= '0; cnt <= '0;
      base_lo <= '0; base_pg <= '0; base_cnt <= '0;
      nx_lo <= '0; nx_pg <= '0; nx_cnt <= '0;
      mode <= '0; active <= 1'b0; done <= 1'b0;
      tc <= 1'b0; chain_req <= 1'b0; next_valid <= 1'b0;
    end else begin
      tc        <= at_tc;
      chain_req <= 1'b0;
      if (next_load) begin
        nx_lo <= next_base; nx_pg <= next_page; nx_cnt <= next_count;
        next_valid <= 1'b1;
      end
      if (start_ok) begin
        cur_lo <= prog_base; cur_pg <= prog_page; cnt <= prog_count;
        base_lo <= prog_base; base_pg <= prog_page; base_cnt <= prog_count;
        mode <= prog_mode; active <= 1'b1; done <= 1'b0;
      end else if (at_tc) begin
        if (mode == M_RING) begin
          cur_lo <= base_lo; cur_pg <= base_pg; cnt <= base_cnt;
        end else if (mode == M_CHAIN && next_valid) begin
          cur_lo <= nx_lo; cur_pg <= nx_pg; cnt <= nx_cnt;
          chain_req <= 1'b1;
          if (!next_load) next_valid <= 1'b0;
        end else begin
          active <= 1'b0; done <= 1'b1;
        end
      end else if (step) begin
        cur_lo <= cur_lo + 16'd1;
        cnt    <= cnt - 16'd1;
      end
    end
  end

  a_r3_cascade_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_start && prog_ch == CH_W'(CASCADE_CH) && !active && !done) |=> (!active && !done));

  a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (active && advance && !prog_start && cnt != 16'd0) |=>
      (addr[15:0] == $past(addr[15:0]) + 16'd1));

  a_r5_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (active && advance && !prog_start && cnt != 16'd0) |=> $stable(addr[PAGE_W+15:16]));

  a_r6_tc_after_active: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc) |-> $past(active));

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !active);

  a_r9_chain_with_tc: assert property (@(posedge clk) disable iff (!rst_n)
    chain_req |-> (tc && active));

  a_r10_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !prog_start) |=> $stable(addr));
endmodule

// File: tb/test_dma_addr_gen.sv
module test_dma_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic prog_start = 0, next_load = 0, advance = 0;
  logic [2:0] prog_ch = 0;
  logic [1:0] prog_mode = 0;
  logic [15:0] prog_base = 0, prog_count = 0, next_base = 0, next_count = 0;
  logic [PW-1:0] prog_page = 0, next_page = 0;
  logic [PW+15:0] addr;
  logic active, done, tc, chain_req, next_valid;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_addr_gen #(.PAGE_W(PW)) i_dma_addr_gen (
    .clk, .rst_n, .prog_start, .prog_ch, .prog_mode, .prog_base, .prog_page,
    .prog_count, .next_load, .next_base, .next_page, .next_count, .advance,
    .addr, .active, .done, .tc, .chain_req, .next_valid);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    prog_start = 0; next_load = 0; advance = 0;
  endtask

  task automatic start(logic [2:0] ch, logic [1:0] m, logic [15:0] b, logic [PW-1:0] p, logic [15:0] c);
    prog_start = 1; prog_ch = ch; prog_mode = m; prog_base = b; prog_page = p; prog_count = c;
    tick();
  endtask

  task automatic adv();
    advance = 1; tick();
  endtask

  task automatic t_reset();
    chk("R1 addr", addr, 0); chk("R1 active", active, 0); chk("R1 done", done, 0);
    chk("R1 tc", tc, 0); chk("R1 chain_req", chain_req, 0); chk("R1 next_valid", next_valid, 0);
  endtask

  task automatic t_cascade();
    start(3'd4, 2'd0, 16'h4444, 8'h44, 16'd3);
    chk("R3 active", active, 0); chk("R3 addr", addr, 0); chk("R3 done", done, 0);
    adv();
    chk("R4 idle advance", addr, 0);
  endtask

  task automatic t_single(logic [1:0] m, string rq);
    start(3'd1, m, 16'h1234, 8'h05, 16'd2);
    chk("R2 addr", addr, 24'h051234); chk("R2 active", active, 1); chk("R2 done", done, 0);
    adv(); chk("R4 step1", addr, 24'h051235); chk("R6 no tc", tc, 0);
    adv(); chk("R4 step2", addr, 24'h051236);
    adv(); chk({"R6 tc ", rq}, tc, 1); chk({rq, " active"}, active, 0);
    chk({rq, " done"}, done, 1); chk({rq, " addr hold"}, addr, 24'h051236);
    tick(); chk("R6 tc pulse", tc, 0);
    adv(); chk({rq, " ignored"}, addr, 24'h051236); chk({rq, " tc idle"}, tc, 0);
  endtask

  task automatic t_wrap();
    start(3'd2, 2'd0, 16'hFFFE, 8'h07, 16'd3);
    adv(); chk("R5 ffff", addr, 24'h07FFFF);
    adv(); chk("R5 wrap page", addr, 24'h070000);
  endtask

  task automatic t_ring();
    start(3'd5, 2'd1, 16'h0010, 8'h01, 16'd1);
    adv(); chk("R8 step", addr, 24'h010011);
    adv(); chk("R8 tc", tc, 1); chk("R8 reload", addr, 24'h010010); chk("R8 active", active, 1);
    adv(); chk("R8 second lap", addr, 24'h010011); chk("R8 tc low", tc, 0);
    adv(); chk("R8 tc again", tc, 1); chk("R8 reload again", addr, 24'h010010);
  endtask

  task automatic t_chain();
    start(3'd6, 2'd2, 16'h0100, 8'h02, 16'd0);
    next_load = 1; next_base = 16'h8000; next_page = 8'h03; next_count = 16'd1;
    tick(); chk("R12 next_valid", next_valid, 1); chk("R12 addr kept", addr, 24'h020100);
    adv(); chk("R9 addr", addr, 24'h038000); chk("R9 chain_req", chain_req, 1);
    chk("R9 tc", tc, 1); chk("R9 next_valid clr", next_valid, 0); chk("R9 active", active, 1);
    adv(); chk("R9 step", addr, 24'h038001); chk("R9 chain_req pulse", chain_req, 0);
    adv(); chk("R10 tc", tc, 1); chk("R10 active", active, 0); chk("R10 done", done, 1);
    chk("R10 no chain_req", chain_req, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_cascade();
    t_single(2'd0, "R7");
    t_single(2'd3, "R11");
    t_wrap();
    t_ring();
    t_chain();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule